// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Composer

This block turns interrupt sources into memory-write messages. A source qualifies when the domain interrupt enable is on and the source is both enabled and pending. For a qualifying source, the block reads that source's target word. The word names a hart index, a guest index and an interrupt identity. The hart index is split into a group part and a hart-local part using widths and shifts held in an address configuration pair. These parts are placed above a base page number to form a 64-bit physical address. One request then leaves on a valid/ready port: the address, plus the identity zero-extended to a 32-bit data word. When that request completes its handshake, the block pulses the source's pending-clear line.

Software can also launch a message directly by writing a generate-message word. This word carries a hart index and an identity, and it is served ahead of any waiting source. A lock bit in the high configuration word freezes both address pairs. The block drives the request port; the fabric that carries the write and the receiving interrupt files sit outside it.

The control is a two-state machine. In `ST_IDLE` the block chooses the next message. The transition `IDLE->SEND` fires when a generate request is waiting or a source qualifies; it latches the address and identity. In `ST_SEND` the request is held. The transition `SEND->IDLE` fires on the cycle `msg_ready` is high, which is the handshake. Otherwise `SEND->SEND` holds every request field.

Top module: `msi_addr_composer`

## Requirements
- R1: Register selects are: 0 domain word, 1 machine address low, 2 machine address high, 3 supervisor address low, 4 supervisor address high, 5 generate-message word; other selects read zero. Only bit 8 (interrupt enable) of the domain word is kept. The high address words keep only mask 0x9F77FFFF: lock bit 31, group shift 28:24, local shift 22:20, group width 18:16, local width 15:12, upper base page 11:0. `rd_data` shows the selected register in the same cycle.
- R2: While bit 31 of the machine high word is set, writes to selects 1 to 4 leave all four words unchanged, and addresses keep using the frozen values.
- R3: For hart index h, the group is h shifted right by the local width, and the local index is h masked to the local width. The page number is the OR of four terms: {high[11:0], low}; the group masked to the group width and shifted left by (group shift + 12); the local index shifted left by the local shift; and the guest index masked to the local shift. `msg_addr` is that page number shifted left by 12.
- R4: A target word holds the hart index in bits 31:18, the guest index in 17:12 and the identity in 10:0. A machine-level domain (the default) uses the machine pair and forces the guest index to zero.
- R5: A source message starts only when the domain enable is set and the source's `src_en` and `src_pend` bits are both 1. `msg_data` is the 11-bit identity, zero-extended.
- R6: `pend_clr` is one-hot, and is non-zero only in a handshake cycle of a source message, for exactly that source.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values. A request appears the cycle after the machine leaves `ST_IDLE`.
- R8: Qualifying sources are served in a rotating order. The search starts at the source after the last source served (index 0 after reset) and wraps past the highest index.
- R9: A write to select 5 queues one message, even when the domain enable is off. Its hart index comes from bits 31:18 and its identity from bits 10:0, with guest index zero. This message goes ahead of waiting sources. Select 5 reads back the written value with bits 17:12 cleared.
- R10: When the child-domain count parameter is non-zero (default 1), the supervisor pair is writable with the same masking as the machine pair. When it is zero, the pair reads zero.
- R11: After reset every register reads zero, `msg_valid` is low and `pend_clr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for writes |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data for `rd_sel` |
| src_pend | input | NUM_SRC | Per-source pending bits |
| src_en | input | NUM_SRC | Per-source enable bits |
| src_target | input | NUM_SRC*32 | Per-source target words, source i in bits 32i+31:32i |
| pend_clr | output | NUM_SRC | One-cycle pending clear on handshake |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Physical write address |
| msg_data | output | 32 | Identity, written as a little-endian 32-bit word |

## Verification
The assertions assume three things about the inputs. First, the `src_pend` bit of a source is dropped no later than the cycle after its `pend_clr` pulse. Second, `msg_ready` is a plain level with no dependence on future state. Third, `cfg_sel` values 6 and 7 are only harmless no-ops. The stimulus meets these conditions in the following ways. Pending bits are cleared in the same cycle that `pend_clr` is seen. `msg_ready` either follows a fixed duty pattern or is held by hand across whole cycles. Writes use only selects 0 to 5. Target words and configuration values are chosen so that group and local fields, plus a non-zero guest index, all land on distinct address bits.

// File: rtl/msi_comp_pkg.sv
package msi_comp_pkg;
    localparam int TGT_HART_LSB  = 18;
    localparam int TGT_HART_W    = 14;
    localparam int TGT_GUEST_LSB = 12;
    localparam int TGT_GUEST_W   = 6;
    localparam int TGT_ID_W      = 11;
    localparam int DOM_IE_BIT    = 8;
    localparam int LOCK_BIT      = 31;
    localparam logic [31:0] HI_KEEP_MASK  = 32'h9F77_FFFF;
    localparam logic [31:0] GEN_KEEP_MASK = 32'hFFFC_0FFF;

    typedef enum logic [2:0] {
        SEL_DOMAIN = 3'd0,
        SEL_M_LO   = 3'd1,
        SEL_M_HI   = 3'd2,
        SEL_S_LO   = 3'd3,
        SEL_S_HI   = 3'd4,
        SEL_GEN    = 3'd5
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } fsm_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_comp_pkg::*;
#(
    parameter int CHILD_DOMAINS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        dom_ie,
    output logic [31:0] m_lo,
    output logic [31:0] m_hi,
    output logic [31:0] s_lo,
    output logic [31:0] s_hi,
    output logic [31:0] gen_word,
    output logic        gen_strobe
);
    logic locked;
    logic dom_ie_q;
    logic [31:0] m_lo_q, m_hi_q, gen_q;

    assign locked     = m_hi_q[LOCK_BIT];
    assign gen_strobe = cfg_we && (cfg_sel == SEL_GEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_ie_q <= 1'b0;
            m_lo_q   <= '0;
            m_hi_q   <= '0;
            gen_q    <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_DOMAIN: dom_ie_q <= cfg_wdata[DOM_IE_BIT];
                SEL_M_LO:   if (!locked) m_lo_q <= cfg_wdata;
                SEL_M_HI:   if (!locked) m_hi_q <= cfg_wdata & HI_KEEP_MASK;
                SEL_GEN:    gen_q <= cfg_wdata & GEN_KEEP_MASK;
                default:    ;
            endcase
        end
    end

    generate
        if (CHILD_DOMAINS > 0) begin : g_sup_pair
            logic [31:0] s_lo_q, s_hi_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_lo_q <= '0;
                    s_hi_q <= '0;
                end else if (cfg_we && !locked) begin
                    if (cfg_sel == SEL_S_LO) s_lo_q <= cfg_wdata;
                    if (cfg_sel == SEL_S_HI) s_hi_q <= cfg_wdata & HI_KEEP_MASK;
                end
            end
            assign s_lo = s_lo_q;
            assign s_hi = s_hi_q;
        end else begin : g_no_sup_pair
            assign s_lo = '0;
            assign s_hi = '0;
        end
    endgenerate

    assign dom_ie   = dom_ie_q;
    assign m_lo     = m_lo_q;
    assign m_hi     = m_hi_q;
    assign gen_word = gen_q;

    always_comb begin
        case (rd_sel)
            SEL_DOMAIN: rd_data = 32'(dom_ie_q) << DOM_IE_BIT;
            SEL_M_LO:   rd_data = m_lo_q;
            SEL_M_HI:   rd_data = m_hi_q;
            SEL_S_LO:   rd_data = s_lo;
            SEL_S_HI:   rd_data = s_hi;
            SEL_GEN:    rd_data = gen_q;
            default:    rd_data = '0;
        endcase
    end

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cfg_we && (cfg_sel inside {SEL_M_LO, SEL_M_HI, SEL_S_LO, SEL_S_HI}))
        |=> ($stable(m_lo_q) && $stable(m_hi_q) && $stable(s_lo) && $stable(s_hi))); // R2
endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
    import msi_comp_pkg::*;
(
    input  logic [31:0]            base_lo,
    input  logic [31:0]            base_hi,
    input  logic [TGT_HART_W-1:0]  hart,
    input  logic [TGT_GUEST_W-1:0] guest,
    output logic [63:0]            msg_addr
);
    logic [2:0]  lo_shift;
    logic [3:0]  lo_width;
    logic [4:0]  hi_shift;
    logic [2:0]  hi_width;
    logic [63:0] hart_w, guest_w, group_idx, local_idx, grp_term, ppn;
    logic        unused_hi_bits;

    assign lo_shift = base_hi[22:20];
    assign lo_width = base_hi[15:12];
    assign hi_shift = base_hi[28:24];
    assign hi_width = base_hi[18:16];
    assign unused_hi_bits = ^{base_hi[31:29], base_hi[23], base_hi[19]};

    assign hart_w    = 64'(hart);
    assign guest_w   = 64'(guest);
    assign group_idx = hart_w >> lo_width;
    assign local_idx = hart_w & ((64'd1 << lo_width) - 64'd1);
    assign grp_term  = (group_idx & ((64'd1 << hi_width) - 64'd1))
                       << (7'(hi_shift) + 7'd12);
    assign ppn = {20'd0, base_hi[11:0], base_lo}
               | grp_term
               | (local_idx << lo_shift)
               | (guest_w & ((64'd1 << lo_shift) - 64'd1));
    assign msg_addr = ppn << 12;
endmodule

// File: rtl/msi_rr_pick.sv
module msi_rr_pick #(
    parameter int N = 8,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [IDXW-1:0] start,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(start) + k) % N;
            if (req[j]) begin
                any = 1'b1;
                idx = IDXW'(j);
            end
        end
    end
endmodule

// File: rtl/msi_addr_composer.sv
module msi_addr_composer
    import msi_comp_pkg::*;
#(
    parameter int NUM_SRC       = 8,
    parameter int CHILD_DOMAINS = 1,
    parameter bit MACHINE_LEVEL = 1'b1,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [31:0]           cfg_wdata,
    input  logic [2:0]            rd_sel,
    output logic [31:0]           rd_data,
    input  logic [NUM_SRC-1:0]    src_pend,
    input  logic [NUM_SRC-1:0]    src_en,
    input  logic [NUM_SRC*32-1:0] src_target,
    output logic [NUM_SRC-1:0]    pend_clr,
    output logic                  msg_valid,
    input  logic                  msg_ready,
    output logic [63:0]           msg_addr,
    output logic [31:0]           msg_data
);
    fsm_e state_q, state_d;
    logic dom_ie, gen_strobe, gen_req_q, cur_gen_q, pick_any, load, hs;
    logic [31:0] m_lo, m_hi, s_lo, s_hi, gen_word, pick_word, ld_word;
    logic [NUM_SRC-1:0] qual;
    logic [IDXW-1:0] pick_idx, cur_src_q, rr_ptr_q;
    logic [TGT_HART_W-1:0]  ld_hart;
    logic [TGT_GUEST_W-1:0] ld_guest;
    logic [63:0] calc_addr, addr_q;
    logic [TGT_ID_W-1:0] id_q;
    logic unused_word_bit;

    msi_cfg_regs #(.CHILD_DOMAINS(CHILD_DOMAINS)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .dom_ie(dom_ie), .m_lo(m_lo), .m_hi(m_hi), .s_lo(s_lo), .s_hi(s_hi),
        .gen_word(gen_word), .gen_strobe(gen_strobe)
    );

    assign qual = src_pend & src_en & {NUM_SRC{dom_ie}};

    msi_rr_pick #(.N(NUM_SRC)) pick_i (
        .req(qual), .start(rr_ptr_q), .any(pick_any), .idx(pick_idx)
    );

    assign pick_word = src_target[32*int'(pick_idx) +: 32];
    assign ld_word   = gen_req_q ? gen_word : pick_word;
    assign ld_hart   = ld_word[TGT_HART_LSB +: TGT_HART_W];
    assign ld_guest  = (MACHINE_LEVEL || gen_req_q) ? '0
                                                    : ld_word[TGT_GUEST_LSB +: TGT_GUEST_W];
    assign unused_word_bit = ld_word[11];

    msi_addr_calc calc_i (
        .base_lo (MACHINE_LEVEL ? m_lo : s_lo),
        .base_hi (MACHINE_LEVEL ? m_hi : s_hi),
        .hart    (ld_hart),
        .guest   (ld_guest),
        .msg_addr(calc_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (gen_req_q || pick_any) state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_IDLE;
        endcase
    end

    assign load = (state_q == ST_IDLE) && (state_d == ST_SEND);
    assign hs   = (state_q == ST_SEND) && msg_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_req_q <= 1'b0;
            cur_gen_q <= 1'b0;
            cur_src_q <= '0;
            rr_ptr_q  <= '0;
            addr_q    <= '0;
            id_q      <= '0;
        end else begin
            if (gen_strobe)              gen_req_q <= 1'b1;
            else if (load && gen_req_q)  gen_req_q <= 1'b0;
            if (load) begin
                addr_q    <= calc_addr;
                id_q      <= ld_word[TGT_ID_W-1:0];
                cur_gen_q <= gen_req_q;
                cur_src_q <= pick_idx;
            end
            if (hs && !cur_gen_q)
                rr_ptr_q <= (cur_src_q == IDXW'(NUM_SRC - 1)) ? '0 : cur_src_q + 1'b1;
        end
    end

    assign msg_valid = (state_q == ST_SEND);
    assign msg_addr  = addr_q;
    assign msg_data  = 32'(id_q);
    assign pend_clr  = (hs && !cur_gen_q) ? (NUM_SRC'(1) << cur_src_q) : '0;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R7
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr)); // R6
    AST_CLR_AT_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_clr) |-> (msg_valid && msg_ready)); // R6
    AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid) && !cur_gen_q) |-> $past(dom_ie)); // R5
endmodule

// File: tb/msi_addr_composer_tb_top.sv
module msi_addr_composer_tb_top;
    localparam int NSRC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0] rd_sel;
    logic [31:0] rd_data;
    logic [NSRC-1:0] src_pend = '0, src_en = '0, pend_clr;
    logic [NSRC*32-1:0] tgt_flat;
    logic msg_valid, msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    always #5 clk = ~clk;

    msi_addr_composer #(.NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .src_pend(src_pend), .src_en(src_en), .src_target(tgt_flat),
        .pend_clr(pend_clr), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int vectors = 0, miscompares = 0, clr_count = 0, cyc = 0, cyc_n = 0;
    bit cmp_on = 0, ready_auto = 0, ready_man = 0, rd_force = 0;
    logic [2:0] rd_fsel = '0, auto_sel = '0;
    assign rd_sel = rd_force ? rd_fsel : auto_sel;
    longint unsigned cap_addr[$];
    int unsigned cap_data[$];

    // behavioural reference model
    bit m_ie, m_gen_req, m_busy, m_cur_gen;
    bit [31:0] m_lo, m_hi, s_lo, s_hi, m_gen;
    int m_cur_src, m_ptr;
    longint unsigned m_addr;
    int unsigned m_data;

    function automatic longint unsigned compose(bit [31:0] lo, bit [31:0] hi, int hart, int guest);
        longint unsigned p, grp, loc, ppn;
        int lhxs, lhxw, hhxs, hhxw;
        lhxs = int'(hi[22:20]); lhxw = int'(hi[15:12]);
        hhxs = int'(hi[28:24]); hhxw = int'(hi[18:16]);
        p   = longint'(2) ** lhxw;
        grp = longint'(hart) / p;
        loc = longint'(hart) % p;
        grp = grp % (longint'(2) ** hhxw);
        ppn = (longint'(hi[11:0]) << 32) | longint'(lo) | (grp << (hhxs + 12))
            | (loc << lhxs) | (longint'(guest) % (longint'(2) ** lhxs));
        return ppn << 12;
    endfunction

    function automatic bit [31:0] model_read(logic [2:0] s);
        case (s)
            3'd0: return m_ie ? 32'h100 : 32'h0;
            3'd1: return m_lo;
            3'd2: return m_hi;
            3'd3: return s_lo;
            3'd4: return s_hi;
            3'd5: return m_gen;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ie = 0; m_gen_req = 0; m_busy = 0; m_cur_gen = 0;
            m_lo = 0; m_hi = 0; s_lo = 0; s_hi = 0; m_gen = 0;
            m_cur_src = 0; m_ptr = 0; m_addr = 0; m_data = 0;
        end else begin
            bit lk;
            lk = m_hi[31];
            if (m_busy) begin
                if (msg_ready) begin
                    m_busy = 0;
                    if (!m_cur_gen) m_ptr = (m_cur_src + 1) % NSRC;
                end
            end else if (m_gen_req) begin
                m_addr = compose(m_lo, m_hi, int'(m_gen >> 18), 0);
                m_data = m_gen & 32'h7FF;
                m_busy = 1; m_cur_gen = 1; m_gen_req = 0;
            end else if (m_ie) begin
                for (int k = 0; k < NSRC; k++) begin
                    int j;
                    j = (m_ptr + k) % NSRC;
                    if (!m_busy && src_pend[j] && src_en[j]) begin
                        m_addr = compose(m_lo, m_hi, int'(tgt_flat[j*32 +: 32] >> 18), 0);
                        m_data = tgt_flat[j*32 +: 32] & 32'h7FF;
                        m_busy = 1; m_cur_gen = 0; m_cur_src = j;
                    end
                end
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_ie = cfg_wdata[8];
                    3'd1: if (!lk) m_lo = cfg_wdata;
                    3'd2: if (!lk) m_hi = cfg_wdata & 32'h9F77FFFF;
                    3'd3: if (!lk) s_lo = cfg_wdata;
                    3'd4: if (!lk) s_hi = cfg_wdata & 32'h9F77FFFF;
                    3'd5: begin m_gen = cfg_wdata & 32'hFFFC0FFF; m_gen_req = 1; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // stimulus-side drivers
    always @(negedge clk) begin
        cyc_n++;
        auto_sel <= 3'(cyc_n % 6);
        msg_ready <= ready_auto ? ((cyc_n % 3) != 1) : ready_man;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && cmp_on) begin
            logic [NSRC-1:0] exp_clr;
            exp_clr = (m_busy && !m_cur_gen && msg_ready) ? (NSRC'(1) << m_cur_src) : '0;
            chk("R7", "msg_valid", 64'(msg_valid), 64'(m_busy));
            if (m_busy) begin
                chk("R3", "msg_addr", msg_addr, m_addr);
                chk("R5", "msg_data", 64'(msg_data), 64'(m_data));
            end
            chk("R6", "pend_clr", 64'(pend_clr), 64'(exp_clr));
            chk("R1", "rd_data", 64'(rd_data), 64'(model_read(rd_sel)));
            if (msg_valid && msg_ready) begin
                cap_addr.push_back(msg_addr);
                cap_data.push_back(msg_data);
            end
            if (|pend_clr) clr_count++;
            src_pend = src_pend & ~pend_clr;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            miscompares++;
            $display("FAIL R5 watchdog actual=%0d expected=<%0d", cyc, 50000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_force = 1'b1; rd_fsel = s;
        #2;
        chk(tag, "readback", 64'(rd_data), 64'(exp));
        rd_force = 1'b0;
    endtask

    task automatic wait_msgs(input int n);
        while (cap_data.size() < n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tgt_flat[31:0] = 32'h0038_502A;               // hart 14, guest 5, id 0x2A
        for (int j = 1; j < NSRC; j++)
            tgt_flat[j*32 +: 32] = {14'(j * 3), 6'(j), 1'b0, 11'(16 + j)};
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1;
        #2;
        chk("R11", "msg_valid after reset", 64'(msg_valid), 64'd0);
        chk("R11", "pend_clr after reset", 64'(pend_clr), 64'd0);
        for (int s = 0; s < 6; s++) rd_chk(3'(s), 32'h0, "R11");

        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'h0000_0100, "R1");
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h7FFF_FFFF);
        rd_chk(3'd2, 32'h1F77_FFFF, "R1");
        rd_chk(3'd6, 32'h0, "R1");
        wr(3'd1, 32'h0008_0000);
        wr(3'd2, 32'h0432_2001);
        wr(3'd3, 32'h1234_5678);
        wr(3'd4, 32'h7FFF_FFFF);
        rd_chk(3'd3, 32'h1234_5678, "R10");
        rd_chk(3'd4, 32'h1F77_FFFF, "R10");

        // enable off: nothing leaves
        src_en = '1;
        src_pend = 8'b0010_0101;
        idle(6);
        chk("R5", "no msg with domain enable off", 64'(cap_data.size()), 64'd0);
        src_en = '0;
        wr(3'd0, 32'h100);
        idle(6);
        chk("R5", "no msg with sources disabled", 64'(cap_data.size()), 64'd0);

        ready_auto = 1;
        src_en = '1;
        wait_msgs(3);
        chk("R8", "rr order 1st", 64'(cap_data[0]), 64'h2A);
        chk("R8", "rr order 2nd", 64'(cap_data[1]), 64'h12);
        chk("R8", "rr order 3rd", 64'(cap_data[2]), 64'h15);
        chk("R3", "composed address src0", cap_addr[0], 64'h0000_1000_B001_0000);
        chk("R4", "guest index ignored", cap_addr[0] & 64'h7000, 64'h0);

        src_pend = 8'b0010_0010;
        wait_msgs(5);
        chk("R8", "rr wrap 1st", 64'(cap_data[3]), 64'h11);
        chk("R8", "rr wrap 2nd", 64'(cap_data[4]), 64'h15);
        idle(2);
        chk("R6", "pending clears", 64'(clr_count), 64'd5);

        // generate message ahead of a waiting source
        ready_auto = 0; ready_man = 0;
        idle(2);
        src_pend[4] = 1'b1;
        while (!msg_valid) @(negedge clk);
        src_pend[3] = 1'b1;
        wr(3'd5, 32'h0004_F123);
        idle(3);
        chk("R7", "request held while not ready", 64'(msg_valid), 64'd1);
        chk("R7", "data held", 64'(msg_data), 64'h14);
        ready_man = 1;
        wait_msgs(8);
        chk("R9", "generate first", 64'(cap_data[6]), 64'h123);
        chk("R9", "generate address", cap_addr[6], 64'h0000_1000_8000_8000);
        chk("R8", "source after generate", 64'(cap_data[7]), 64'h13);
        rd_chk(3'd5, 32'h0004_0123, "R9");

        wr(3'd0, 32'h0);
        wr(3'd5, 32'h0000_0456);
        wait_msgs(9);
        chk("R9", "generate with enable off", 64'(cap_data[8]), 64'h456);
        chk("R9", "generate hart 0 address", cap_addr[8], 64'h0000_1000_8000_0000);

        // lock
        wr(3'd2, 32'h8432_2001);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0);
        rd_chk(3'd1, 32'h0008_0000, "R2");
        rd_chk(3'd2, 32'h8432_2001, "R2");
        rd_chk(3'd3, 32'h1234_5678, "R2");
        wr(3'd5, 32'h0038_0033);
        wait_msgs(10);
        chk("R2", "locked address used", cap_addr[9], 64'h0000_1000_B001_0000);
        idle(4);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule